// File: doc/BRIEF.md
# Register-Programmed Stream Routing Crossbar

This block connects a parameterised set of stream inputs to a set of stream outputs. Each output has a routing word that names one input as its source, or marks the output as switched off. Software programs the routing over a small 32-bit word-addressed register port with separate write and read strobes.

Routing words are staged. A write changes only a staged copy, and the staged copy is the one that reads return. The data path follows a separate live copy. Software asks for the staged words to be applied by setting a request bit in the control word. The hardware applies them only when no output is in the middle of a packet, and then it clears the request bit.

Several outputs can name the same input. In that case the input advances only when all of those outputs accept the beat together, so every one of them receives every beat exactly once.

Top module: `stream_route_xbar`

## Requirements
- R1: After reset every output is switched off. Every routing word reads 0x8000_0000, the control word reads 0, `m_valid` is all zero and `s_ready` is all zero.
- R2: The control word is at word address 0, which is byte 0x000. The routing word for output m is at word address 16+m, which is byte 0x040+4·m. In a routing word, bits [3:0] hold the source index and bit 31 is the off flag. In the control word, bit 1 is the apply request. All other bits read as zero and ignore writes. `cfg_rdata` is zero while `cfg_rd` is low.
- R3: A routing write changes only the staged copy. A read returns the staged value. Outputs keep their old routing until the staged copy is applied.
- R4: Writing the control word with bit 1 set raises the request, and the request reads back as 1. When no output holds an open packet, the live routing loads from the staged copy on the next clock edge and the request bit reads 0 again.
- R5: An output holds an open packet from the moment it accepts a beat without `m_last` until it accepts a beat with `m_last`. While any output holds an open packet, the request stays pending and the live routing does not change.
- R6: An enabled output presents the valid, data and last of its source input. When that input feeds only this output, the input's `s_ready` equals the output's `m_ready`.
- R7: A switched-off output drives `m_valid`, `m_last` and `m_data` to zero. An input that no enabled output selects sees `s_ready` low.
- R8: When several enabled outputs select one input, that input's `s_ready` is the AND of their `m_ready`. Each of those outputs asserts `m_valid` only when all of them are ready.
- R9: Writes to routing words for outputs at or above NUM_MI are ignored, and reads of them return 0. A source index at or above NUM_SI is stored and read back unchanged. While it is live, the output behaves as switched off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | ADDR_W | Word address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational from address while `cfg_rd` is high |
| s_valid | input | NUM_SI | Per-input beat valid |
| s_ready | output | NUM_SI | Per-input beat ready |
| s_last | input | NUM_SI | Per-input end of packet |
| s_data | input | NUM_SI*DATA_W | Per-input data, input i in slice i |
| m_valid | output | NUM_MI | Per-output beat valid |
| m_ready | input | NUM_MI | Per-output beat ready |
| m_last | output | NUM_MI | Per-output end of packet |
| m_data | output | NUM_MI*DATA_W | Per-output data, output m in slice m |

## Verification
The hardest case to reach from the ports is an apply request that arrives while a packet is half delivered. The request must then wait, with the old route still carrying traffic, and take effect only after the closing beat. The stimulus gets there as follows. It opens a packet with one accepted beat that has last low, then stages a new route and raises the request. For several cycles it checks that the request bit stays set and that the old route still forwards data. It then sends the closing beat and checks that the new route appears exactly one edge later.

// File: rtl/stream_xbar_pkg.sv
package stream_xbar_pkg;
  localparam int unsigned SRC_W      = 4;
  localparam int unsigned ROUTE_BASE = 16;
  localparam int unsigned REQ_BIT    = 1;
  localparam int unsigned OFF_BIT    = 31;

  typedef struct packed {
    logic             off;
    logic [SRC_W-1:0] src;
  } route_t;

  localparam route_t ROUTE_RESET = '{off: 1'b1, src: '0};

  function automatic logic [31:0] pack_route(route_t r);
    logic [31:0] w;
    w = '0;
    w[OFF_BIT] = r.off;
    w[SRC_W-1:0] = r.src;
    return w;
  endfunction

  function automatic route_t unpack_route(logic [31:0] w);
    route_t r;
    r.off = w[OFF_BIT];
    r.src = w[SRC_W-1:0];
    return r;
  endfunction

  function automatic logic route_live(route_t r, int unsigned nsi);
    return !r.off && (32'(r.src) < nsi);
  endfunction
endpackage

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs
  import stream_xbar_pkg::*;
#(
  parameter int unsigned NUM_MI = 3,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic                      cfg_rd,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [31:0]               cfg_wdata,
  output logic [31:0]               cfg_rdata,
  input  logic                      all_idle,
  output route_t [NUM_MI-1:0]       live_route,
  output logic                      commit_fire
);
  route_t [NUM_MI-1:0] staged_q;
  route_t [NUM_MI-1:0] live_q;
  logic                commit_pend;
  logic                ctrl_set;

  assign ctrl_set    = cfg_wr && (cfg_addr == '0) && cfg_wdata[REQ_BIT];
  assign commit_fire = commit_pend && all_idle;
  assign live_route  = live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_pend <= 1'b0;
      for (int m = 0; m < NUM_MI; m++) begin
        staged_q[m] <= ROUTE_RESET;
        live_q[m]   <= ROUTE_RESET;
      end
    end else begin
      if (ctrl_set)         commit_pend <= 1'b1;
      else if (commit_fire) commit_pend <= 1'b0;
      for (int m = 0; m < NUM_MI; m++) begin
        if (cfg_wr && cfg_addr == ADDR_W'(ROUTE_BASE + m))
          staged_q[m] <= unpack_route(cfg_wdata);
        if (commit_fire)
          live_q[m] <= staged_q[m];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_rd) begin
      if (cfg_addr == '0) cfg_rdata[REQ_BIT] = commit_pend;
      for (int m = 0; m < NUM_MI; m++)
        if (cfg_addr == ADDR_W'(ROUTE_BASE + m)) cfg_rdata = pack_route(staged_q[m]);
    end
  end

  // R3: live routing only moves on an apply edge
  p_live_moves_on_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_q) |-> $past(commit_fire));

  // R4: an apply without a fresh request leaves the request bit clear
  p_request_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && !ctrl_set) |=> !commit_pend);
endmodule

// File: rtl/xbar_pkt_track.sv
module xbar_pkt_track #(
  parameter int unsigned NUM_MI = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_MI-1:0] m_valid,
  input  logic [NUM_MI-1:0] m_ready,
  input  logic [NUM_MI-1:0] m_last,
  output logic [NUM_MI-1:0] pkt_open,
  output logic              all_idle
);
  always_ff @(posedge clk) begin
    if (!rst_n) pkt_open <= '0;
    else
      for (int m = 0; m < NUM_MI; m++)
        if (m_valid[m] && m_ready[m]) pkt_open[m] <= !m_last[m];
  end

  assign all_idle = ~|pkt_open;
endmodule

// File: rtl/xbar_fabric.sv
module xbar_fabric
  import stream_xbar_pkg::*;
#(
  parameter int unsigned NUM_SI = 4,
  parameter int unsigned NUM_MI = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  route_t [NUM_MI-1:0]        route,
  input  logic [NUM_SI-1:0]          s_valid,
  output logic [NUM_SI-1:0]          s_ready,
  input  logic [NUM_SI-1:0]          s_last,
  input  logic [NUM_SI*DATA_W-1:0]   s_data,
  output logic [NUM_MI-1:0]          m_valid,
  input  logic [NUM_MI-1:0]          m_ready,
  output logic [NUM_MI-1:0]          m_last,
  output logic [NUM_MI*DATA_W-1:0]   m_data
);
  logic [NUM_MI-1:0]             out_on;
  logic [NUM_SI-1:0][NUM_MI-1:0] fan;
  logic [NUM_SI-1:0]             group_rdy;

  for (genvar m = 0; m < NUM_MI; m++) begin : g_on
    assign out_on[m] = route_live(route[m], NUM_SI);
  end

  for (genvar i = 0; i < NUM_SI; i++) begin : g_in
    for (genvar m = 0; m < NUM_MI; m++) begin : g_fan
      assign fan[i][m] = out_on[m] && (route[m].src == SRC_W'(i));
    end
    assign group_rdy[i] = &(m_ready | ~fan[i]);
    assign s_ready[i]   = (|fan[i]) && group_rdy[i];
  end

  for (genvar m = 0; m < NUM_MI; m++) begin : g_out
    logic              v_sel, l_sel;
    logic [DATA_W-1:0] d_sel;
    always_comb begin
      v_sel = 1'b0;
      l_sel = 1'b0;
      d_sel = '0;
      for (int i = 0; i < NUM_SI; i++)
        if (fan[i][m]) begin
          v_sel = s_valid[i] && group_rdy[i];
          l_sel = s_last[i];
          d_sel = s_data[i*DATA_W +: DATA_W];
        end
    end
    assign m_valid[m] = v_sel;
    assign m_last[m]  = l_sel;
    assign m_data[m*DATA_W +: DATA_W] = d_sel;

    // R7: a switched-off output never offers a beat
    p_off_is_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_on[m] |-> (!m_valid[m] && !m_last[m]));
  end

  for (genvar i = 0; i < NUM_SI; i++) begin : g_chk
    for (genvar m = 0; m < NUM_MI; m++) begin : g_pair
      // R8: an accepted input beat is taken by every output in its group
      p_group_lockstep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid[i] && s_ready[i] && fan[i][m]) |-> (m_valid[m] && m_ready[m]));
      // R6: an output beat always comes from a valid source input
      p_beat_has_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid[m] && fan[i][m]) |-> s_valid[i]);
    end
  end
endmodule

// File: rtl/stream_route_xbar.sv
module stream_route_xbar
  import stream_xbar_pkg::*;
#(
  parameter int unsigned NUM_SI = 4,
  parameter int unsigned NUM_MI = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic                       cfg_rd,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [31:0]                cfg_wdata,
  output logic [31:0]                cfg_rdata,
  input  logic [NUM_SI-1:0]          s_valid,
  output logic [NUM_SI-1:0]          s_ready,
  input  logic [NUM_SI-1:0]          s_last,
  input  logic [NUM_SI*DATA_W-1:0]   s_data,
  output logic [NUM_MI-1:0]          m_valid,
  input  logic [NUM_MI-1:0]          m_ready,
  output logic [NUM_MI-1:0]          m_last,
  output logic [NUM_MI*DATA_W-1:0]   m_data
);
  route_t [NUM_MI-1:0] live_route;
  logic                commit_fire;
  logic                all_idle;
  logic [NUM_MI-1:0]   pkt_open;

  xbar_cfg_regs #(.NUM_MI(NUM_MI), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .all_idle(all_idle), .live_route(live_route), .commit_fire(commit_fire)
  );

  xbar_pkt_track #(.NUM_MI(NUM_MI)) u_track (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_last(m_last), .pkt_open(pkt_open), .all_idle(all_idle)
  );

  xbar_fabric #(.NUM_SI(NUM_SI), .NUM_MI(NUM_MI), .DATA_W(DATA_W)) u_fabric (
    .clk(clk), .rst_n(rst_n), .route(live_route),
    .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_last(m_last), .m_data(m_data)
  );

  // R5: routing only swaps on an edge where no output held an open packet
  p_swap_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_route) |-> $past(~|pkt_open));
endmodule

// File: tb/tb_stream_route_xbar.sv
module tb_stream_route_xbar;
  localparam int NSI = 4;
  localparam int NMI = 3;
  localparam int DW  = 8;
  localparam int AW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [NSI-1:0] sv = '0, sr, sl = '1;
  logic [NSI*DW-1:0] sd;
  logic [NMI-1:0] mv, mr = '0, ml;
  logic [NMI*DW-1:0] md;

  int n_run = 0, n_fail = 0;
  logic [31:0] rd;

  assign sd = {8'hA3, 8'hA2, 8'hA1, 8'hA0};

  always #5 clk = ~clk;

  stream_route_xbar #(.NUM_SI(NSI), .NUM_MI(NMI), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .s_valid(sv), .s_ready(sr),
    .s_last(sl), .s_data(sd), .m_valid(mv), .m_ready(mr), .m_last(ml), .m_data(md)
  );

  // {s_valid[3:0], m_ready[2:0], expected s_ready[3:0], expected m_valid[2:0]}
  // routing under test: out0<-in1, out1<-in1, out2<-in3
  localparam logic [13:0] VEC [6] = '{
    {4'b1111, 3'b111, 4'b1010, 3'b111},
    {4'b1111, 3'b110, 4'b1000, 3'b100},
    {4'b0010, 3'b111, 4'b1010, 3'b011},
    {4'b1000, 3'b011, 4'b0010, 3'b000},
    {4'b0000, 3'b000, 4'b0000, 3'b000},
    {4'b1010, 3'b101, 4'b1000, 3'b100}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(int a, output logic [31:0] d);
    cfg_rd = 1'b1; cfg_addr = AW'(a);
    #1 d = cfg_rdata;
    cfg_rd = 1'b0;
  endtask

  task automatic apply_now();
    wr_reg(0, 32'h2);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    sv = 4'b1111; mr = 3'b111; #1;
    check("R1 m_valid", 32'(mv), 32'h0);
    check("R1 s_ready", 32'(sr), 32'h0);
    sv = '0;
    for (int m = 0; m < NMI; m++) begin
      rd_reg(16 + m, rd);
      check("R1 route word", rd, 32'h8000_0000);
    end
    rd_reg(0, rd);
    check("R1 control", rd, 32'h0);

    // R2 field layout, R3 staged only
    wr_reg(16, 32'h7FFF_FF71);
    rd_reg(16, rd);
    check("R2 masked readback", rd, 32'h0000_0001);
    sv = 4'b1111; mr = 3'b111; #1;
    check("R3 no effect before apply", 32'(mv), 32'h0);
    sv = '0;

    // R4 apply handshake
    wr_reg(0, 32'hFFFF_FFFF);
    rd_reg(0, rd);
    check("R4 request pending", rd, 32'h2);
    @(negedge clk);
    rd_reg(0, rd);
    check("R4 request cleared", rd, 32'h0);
    sv = 4'b0010; mr = 3'b001; #1;
    check("R6 out0 valid", 32'(mv), 32'h1);
    check("R6 out0 data", 32'(md[7:0]), 32'hA1);
    check("R6 in1 ready", 32'(sr), 32'h2);
    sv = '0;

    // R6 R8 vector table
    wr_reg(16, 32'h1); wr_reg(17, 32'h1); wr_reg(18, 32'h3);
    apply_now();
    for (int k = 0; k < 6; k++) begin
      sv = VEC[k][13:10]; mr = VEC[k][9:7]; sl = 4'b1111; #1;
      check("R8 table s_ready", 32'(sr), 32'(VEC[k][6:3]));
      check("R8 table m_valid", 32'(mv), 32'(VEC[k][2:0]));
      if (k == 0) begin
        check("R6 out0 data", 32'(md[7:0]), 32'hA1);
        check("R8 out1 data", 32'(md[15:8]), 32'hA1);
        check("R6 out2 data", 32'(md[23:16]), 32'hA3);
        check("R6 out2 last", 32'(ml[2]), 32'h1);
      end
      @(negedge clk);
    end
    sv = '0; mr = '0;

    // R9 absent output, unmapped word, out-of-range source; R2 read strobe low
    wr_reg(19, 32'h5);
    rd_reg(19, rd);
    check("R9 absent output reads zero", rd, 32'h0);
    rd_reg(5, rd);
    check("R2 unmapped word", rd, 32'h0);
    cfg_addr = AW'(16); #1;
    check("R2 rdata idle", cfg_rdata, 32'h0);
    wr_reg(17, 32'h6);
    rd_reg(17, rd);
    check("R9 big source readback", rd, 32'h6);
    apply_now();
    sv = 4'b1111; mr = 3'b111; #1;
    check("R9 big source idles output", 32'(mv), 32'h5);
    check("R7 off output data", 32'(md[15:8]), 32'h0);
    check("R7 unselected inputs", 32'(sr & 4'b0101), 32'h0);
    sv = '0;

    // R5 apply deferred by an open packet on out2 (out2<-in3)
    sv = 4'b1000; sl = 4'b0000; mr = 3'b111;
    @(negedge clk);
    sv = '0;
    wr_reg(18, 32'h8000_0000);
    wr_reg(0, 32'h2);
    repeat (3) @(negedge clk);
    rd_reg(0, rd);
    check("R5 request held", rd, 32'h2);
    sv = 4'b1000; sl = 4'b1000; mr = 3'b100; #1;
    check("R5 old route still live", 32'(mv[2]), 32'h1);
    check("R5 old route data", 32'(md[23:16]), 32'hA3);
    @(negedge clk);
    sv = '0;
    @(negedge clk);
    rd_reg(0, rd);
    check("R5 applied after last", rd, 32'h0);
    sv = 4'b1000; mr = 3'b111; #1;
    check("R7 now off", 32'(mv[2]), 32'h0);
    check("R7 in3 not ready", 32'(sr[3]), 32'h0);
    sv = '0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule